// File: doc/BRIEF.md
# Scheduled Transfer List Sequencer

This block holds a short program of outgoing transfer items for one group of serial front-end links and plays it back once started. Each item pairs a payload word with a wait count. The wait is measured in bunch-crossing ticks, which arrive as a one-cycle strobe on `tick` and run at 40 MHz inside a faster core clock. When an item's wait has elapsed, the item fires. Its payload is then presented, with a one-cycle valid strobe, on every link lane that the configured link mask selects.

Playback starts in one of two ways. The host can pulse a start input. Alternatively, if hardware start is enabled, one selected bit of the timing-system user bits can start it when that bit is seen in a tick cycle. While the list is playing, a second start is not honoured and only increments an overrun counter. Host writes to list entries or to configuration are dropped, and each dropped write is flagged. Serializing and encoding the payload happen downstream and are not part of this block.

Top module: `sched_list_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, every `link_valid` bit, all of `link_data`, `overrun_cnt` and `wr_reject` read zero.
- R2: A `host_start` pulse in a cycle where `busy` is low and the configured length is non-zero sets `busy` in the next cycle. With a configured length of zero, a start does nothing at all.
- R3: A hardware start happens only in a cycle where `tick`, `cfg_hw_en` and `user_bits[cfg_trig_sel]` are all high. A selected bit outside a tick cycle, a non-selected bit, or any bit while `cfg_hw_en` is low does not start playback.
- R4: Entry 0 fires on the (d0+1)-th tick that comes strictly after the activation cycle, where d0 is its stored delay. A tick in the activation cycle is not counted. Its strobe appears in the cycle after that tick.
- R5: Entry k (k>0) fires on the (dk+1)-th tick after the tick on which entry k-1 fired. A delay of 0 therefore fires on the very next tick.
- R6: On a firing, `link_valid` equals `cfg_link_en` for exactly one cycle. Lane i of `link_data` (bits i*DATA_W upward) carries the entry's payload when bit i is set and zero otherwise. Every lane is zero outside strobe cycles.
- R7: Entries 0 to len-1 play in ascending index order and playback then stops. `busy` stays high from the cycle after activation up to and including the cycle in which the last tick fires, and is low in the cycle that shows the last strobe.
- R8: Each cycle in which a start request (host or hardware) is seen while `busy` is high is ignored for playback and adds one to `overrun_cnt`, which saturates at its all-ones value.
- R9: An entry or configuration write made while `busy` is high changes nothing. `wr_reject` is high for one cycle, in the cycle after the dropped write.
- R10: A configured length above DEPTH is stored as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per bunch crossing |
| ent_we | input | 1 | Write strobe for a list entry |
| ent_idx | input | IDX_W | Entry index to write |
| ent_delay | input | DELAY_W | Wait in ticks for the written entry |
| ent_payload | input | DATA_W | Payload word for the written entry |
| cfg_we | input | 1 | Write strobe for the configuration |
| cfg_len | input | LEN_W | Number of entries to play |
| cfg_link_en | input | N_LINKS | Mask of target links |
| cfg_trig_sel | input | SEL_W | Which user bit acts as hardware start |
| cfg_hw_en | input | 1 | Enables the hardware start |
| user_bits | input | UB_W | Timing-system user bits |
| host_start | input | 1 | Host start pulse |
| link_valid | output | N_LINKS | Per-link payload strobe |
| link_data | output | N_LINKS*DATA_W | Per-link payload lanes, lane 0 in the low bits |
| busy | output | 1 | High while the list plays |
| overrun_cnt | output | CNT_W | Saturating count of refused starts |
| wr_reject | output | 1 | Flags a write dropped while busy |

## Verification
The list is played with strictly increasing delays, with all-zero delays, and with the largest delay value. Comparing each strobe against its arithmetically predicted tick separates off-by-one errors in the first-entry count (R4) from errors in the inter-entry count (R5), and shows whether a zero delay fires back-to-back. A sweep of all sixteen link masks on a one-entry list shows lane gating and zeroed lanes independently of timing. Start requests are tried through both sources, off-tick, on the wrong bit, with hardware start disabled, with zero length, and repeatedly during playback up to counter saturation. Writes during playback are followed by a replay that shows the old entries and mask were kept.

// File: rtl/sls_pkg.sv
package sls_pkg;

  // Clamp a requested list length to the storage depth.
  function automatic int unsigned clip_len(input int unsigned raw, input int unsigned depth);
    return (raw > depth) ? depth : raw;
  endfunction

  // Saturating increment.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

endpackage

// File: rtl/sls_list_mem.sv
module sls_list_mem #(
  parameter int DEPTH   = 64,
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 12,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DELAY_W-1:0] wr_delay,
  input  logic [DATA_W-1:0]  wr_payload,
  input  logic [IDX_W-1:0]   pay_idx,
  input  logic [IDX_W-1:0]   dly_idx,
  output logic [DATA_W-1:0]  pay_out,
  output logic [DELAY_W-1:0] dly_out
);

  logic [DELAY_W-1:0] dly_q [DEPTH];
  logic [DATA_W-1:0]  pay_q [DEPTH];
  logic               wr_accept;

  assign wr_accept = wr_en & ~busy;

  always_ff @(posedge clk) begin
    if (wr_accept && (int'(wr_idx) < DEPTH)) begin
      dly_q[wr_idx] <= wr_delay;
      pay_q[wr_idx] <= wr_payload;
    end
  end

  assign pay_out = pay_q[pay_idx];
  assign dly_out = dly_q[dly_idx];

  // R9: stored entries do not move while the list plays
  a_r9_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pay_q[0]) && $stable(dly_q[0])));

endmodule

// File: rtl/sls_trigger.sv
module sls_trigger
  import sls_pkg::*;
#(
  parameter int UB_W  = 8,
  parameter int CNT_W = 8,
  localparam int SEL_W = $clog2(UB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [UB_W-1:0]  user_bits,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             hw_en,
  input  logic             host_start,
  input  logic             busy,
  input  logic             len_nz,
  output logic             start,
  output logic             start_req,
  output logic [CNT_W-1:0] overrun_cnt
);

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic hw_req;
  logic [CNT_W-1:0] overrun_q;

  assign hw_req    = hw_en & tick & user_bits[trig_sel];
  assign start_req = host_start | hw_req;
  assign start     = start_req & ~busy & len_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun_q <= '0;
    end else if (start_req && busy) begin
      overrun_q <= CNT_W'(sat_inc(32'(overrun_q), 32'(MAXC)));
    end
  end

  assign overrun_cnt = overrun_q;

  // R8: refused start advances the counter by one below saturation
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy && overrun_q != MAXC) |=> (overrun_q == $past(overrun_q) + 1'b1));

  // R8: saturated counter stays saturated
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_q == MAXC) |=> (overrun_q == MAXC));

  // R3: a start not from the host needs a tick and the enable
  a_r3_hw_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !host_start) |-> (tick && hw_en));

endmodule

// File: rtl/sls_player.sv
module sls_player #(
  parameter int IDX_W   = 6,
  parameter int LEN_W   = 7,
  parameter int DELAY_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [LEN_W-1:0]   len,
  input  logic [DELAY_W-1:0] nxt_delay,
  output logic               busy,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [IDX_W-1:0]   nxt_idx,
  output logic               fire,
  output logic               last
);

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DELAY_W-1:0] rem_q;

  function automatic logic is_last(input logic [IDX_W-1:0] i, input logic [LEN_W-1:0] n);
    return (LEN_W'(i) + LEN_W'(1)) == n;
  endfunction

  function automatic logic is_due(input logic [DELAY_W-1:0] r);
    return r == '0;
  endfunction

  assign nxt_idx = busy_q ? idx_q + 1'b1 : '0;
  assign last    = is_last(idx_q, len);
  assign fire    = busy_q & tick & is_due(rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        rem_q  <= nxt_delay;
      end
    end else if (tick) begin
      if (is_due(rem_q)) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= nxt_idx;
          rem_q <= nxt_delay;
        end
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign cur_idx = idx_q;

  // R2: an accepted start raises busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R4: firings only happen on ticks while playing
  a_r4_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (tick && busy_q));

  // R5: a non-final firing advances the index by one
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (idx_q == $past(idx_q) + 1'b1));

  // R7: busy only drops after the final entry fires
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(fire) && $past(last)));

endmodule

// File: rtl/sls_fanout.sv
module sls_fanout #(
  parameter int N_LINKS = 8,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [DATA_W-1:0]         payload,
  input  logic [N_LINKS-1:0]        link_en,
  output logic [N_LINKS-1:0]        link_valid,
  output logic [N_LINKS*DATA_W-1:0] link_data
);

  for (genvar i = 0; i < N_LINKS; i++) begin : g_lane
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= fire & link_en[i];
        d_q <= (fire & link_en[i]) ? payload : '0;
      end
    end

    assign link_valid[i]                  = v_q;
    assign link_data[i*DATA_W +: DATA_W]  = d_q;

    // R6: a lane strobes only after a firing with its mask bit set
    a_r6_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> ($past(fire) && $past(link_en[i])));
  end

endmodule

// File: rtl/sched_list_seq.sv
module sched_list_seq
  import sls_pkg::*;
#(
  parameter int N_LINKS = 8,
  parameter int DEPTH   = 64,
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 12,
  parameter int UB_W    = 8,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int SEL_W  = $clog2(UB_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      ent_we,
  input  logic [IDX_W-1:0]          ent_idx,
  input  logic [DELAY_W-1:0]        ent_delay,
  input  logic [DATA_W-1:0]         ent_payload,
  input  logic                      cfg_we,
  input  logic [LEN_W-1:0]          cfg_len,
  input  logic [N_LINKS-1:0]        cfg_link_en,
  input  logic [SEL_W-1:0]          cfg_trig_sel,
  input  logic                      cfg_hw_en,
  input  logic [UB_W-1:0]           user_bits,
  input  logic                      host_start,
  output logic [N_LINKS-1:0]        link_valid,
  output logic [N_LINKS*DATA_W-1:0] link_data,
  output logic                      busy,
  output logic [CNT_W-1:0]          overrun_cnt,
  output logic                      wr_reject
);

  // configuration state
  logic [LEN_W-1:0]   len_q;
  logic [N_LINKS-1:0] en_q;
  logic [SEL_W-1:0]   sel_q;
  logic               hw_en_q;
  logic               rej_q;

  // internal events
  logic               play_busy;
  logic               start_ok;
  logic               start_req;
  logic               fire_ev;
  logic               last_ev;
  logic [IDX_W-1:0]   cur_idx;
  logic [IDX_W-1:0]   nxt_idx;
  logic [DATA_W-1:0]  cur_payload;
  logic [DELAY_W-1:0] nxt_delay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      en_q    <= '0;
      sel_q   <= '0;
      hw_en_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= (ent_we | cfg_we) & play_busy;
      if (cfg_we && !play_busy) begin
        len_q   <= LEN_W'(clip_len(32'(cfg_len), DEPTH));
        en_q    <= cfg_link_en;
        sel_q   <= cfg_trig_sel;
        hw_en_q <= cfg_hw_en;
      end
    end
  end

  sls_list_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DELAY_W(DELAY_W)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (play_busy),
    .wr_en      (ent_we),
    .wr_idx     (ent_idx),
    .wr_delay   (ent_delay),
    .wr_payload (ent_payload),
    .pay_idx    (cur_idx),
    .dly_idx    (nxt_idx),
    .pay_out    (cur_payload),
    .dly_out    (nxt_delay)
  );

  sls_trigger #(.UB_W(UB_W), .CNT_W(CNT_W)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .user_bits   (user_bits),
    .trig_sel    (sel_q),
    .hw_en       (hw_en_q),
    .host_start  (host_start),
    .busy        (play_busy),
    .len_nz      (len_q != '0),
    .start       (start_ok),
    .start_req   (start_req),
    .overrun_cnt (overrun_cnt)
  );

  sls_player #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DELAY_W(DELAY_W)) u_play (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (start_ok),
    .len       (len_q),
    .nxt_delay (nxt_delay),
    .busy      (play_busy),
    .cur_idx   (cur_idx),
    .nxt_idx   (nxt_idx),
    .fire      (fire_ev),
    .last      (last_ev)
  );

  sls_fanout #(.N_LINKS(N_LINKS), .DATA_W(DATA_W)) u_fan (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire_ev),
    .payload    (cur_payload),
    .link_en    (en_q),
    .link_valid (link_valid),
    .link_data  (link_data)
  );

  assign busy      = play_busy;
  assign wr_reject = rej_q;

  // R9: a reject flag always traces back to a busy cycle
  a_r9_reject_src: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> $past(play_busy));

  // R9: configuration is frozen during playback
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (play_busy && $past(play_busy)) |-> ($stable(en_q) && $stable(len_q)));

  // R10: the stored length never exceeds the depth
  a_r10_len_clip: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && !play_busy) |-> (32'(len_q) <= DEPTH));

  // R8: a refused start never disturbs an ongoing playback's busy
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && play_busy && !fire_ev) |=> play_busy);

endmodule

// File: tb/sched_list_seq_test.sv
`timescale 1ns/1ps
module sched_list_seq_test;

  localparam int NL = 4;
  localparam int DP = 8;
  localparam int DW = 16;
  localparam int YW = 4;
  localparam int UW = 4;
  localparam int CW = 3;
  localparam int TP = 5;     // core cycles per tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ent_we = 1'b0;
  logic [2:0] ent_idx = '0;
  logic [YW-1:0] ent_delay = '0;
  logic [DW-1:0] ent_payload = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_len = '0;
  logic [NL-1:0] cfg_link_en = '0;
  logic [1:0] cfg_trig_sel = '0;
  logic cfg_hw_en = 1'b0;
  logic [UW-1:0] user_bits = '0;
  logic host_start = 1'b0;
  logic [NL-1:0] link_valid;
  logic [NL*DW-1:0] link_data;
  logic busy;
  logic [CW-1:0] overrun_cnt;
  logic wr_reject;

  sched_list_seq #(.N_LINKS(NL), .DEPTH(DP), .DATA_W(DW), .DELAY_W(YW),
                   .UB_W(UW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ent_we(ent_we), .ent_idx(ent_idx),
    .ent_delay(ent_delay), .ent_payload(ent_payload), .cfg_we(cfg_we),
    .cfg_len(cfg_len), .cfg_link_en(cfg_link_en), .cfg_trig_sel(cfg_trig_sel),
    .cfg_hw_en(cfg_hw_en), .user_bits(user_bits), .host_start(host_start),
    .link_valid(link_valid), .link_data(link_data), .busy(busy),
    .overrun_cnt(overrun_cnt), .wr_reject(wr_reject));

  initial forever #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    tick = (cyc % TP == 0);
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the list
  int          m_dly [DP];
  logic [15:0] m_pay [DP];
  int          m_len = 0;
  logic [3:0]  m_en = '0;
  int          m_sel = 0;
  int          ov_exp = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic clear_drv();
    host_start = 1'b0; user_bits = '0; ent_we = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic load(input int k, input int d, input logic [15:0] p);
    @(negedge clk);
    clear_drv();
    ent_we = 1'b1; ent_idx = 3'(k); ent_delay = YW'(d); ent_payload = p;
    m_dly[k] = d; m_pay[k] = p;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic set_cfg(input int len, input logic [3:0] en, input int sel, input bit hw);
    @(negedge clk);
    clear_drv();
    cfg_we = 1'b1; cfg_len = 4'(len); cfg_link_en = en; cfg_trig_sel = 2'(sel); cfg_hw_en = hw;
    m_len = (len > DP) ? DP : len;   // R10 clamp
    m_en = en; m_sel = sel;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe_idle(input string tag, input int n);
    repeat (n) begin
      @(negedge clk);
      clear_drv();
      chk(busy == 1'b0, tag, 64'(busy), 64'd0);
      chk(link_valid == '0, tag, 64'(link_valid), 64'd0);
    end
  endtask

  // mode 0: plain, 1: three start pulses during play, 2: writes during play
  task automatic play(input bit via_ubit, input int mode);
    int a;
    int t [DP];
    int tl;
    @(negedge clk);
    clear_drv();
    if (via_ubit) begin
      while (cyc % TP != 0) @(negedge clk);
      user_bits = UW'(1 << m_sel);
    end else begin
      host_start = 1'b1;
    end
    a = cyc;
    t[0] = (a / TP + 1) * TP + m_dly[0] * TP;
    for (int k = 1; k < m_len; k++) t[k] = t[k-1] + (m_dly[k] + 1) * TP;
    tl = t[m_len-1];
    for (int c = a + 1; c <= tl + 2; c++) begin
      int hit;
      logic [63:0] ed;
      logic [3:0]  ev;
      @(negedge clk);
      clear_drv();
      if (mode == 1 && c >= a + 3 && c <= a + 5) begin
        host_start = 1'b1;
        ov_exp = (ov_exp >= 7) ? 7 : ov_exp + 1;
      end
      if (mode == 2 && c == a + 2) begin
        ent_we = 1'b1; ent_idx = 3'd0; ent_delay = 4'd9; ent_payload = 16'hDEAD;
        cfg_we = 1'b1; cfg_len = 4'd1; cfg_link_en = ~m_en;
      end
      if (c == a + 1) chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
      else chk(busy == (c <= tl), "R7 busy window", 64'(busy), 64'(c <= tl));
      hit = -1;
      for (int k = 0; k < m_len; k++) if (t[k] == c - 1) hit = k;
      ev = (hit >= 0) ? m_en : 4'd0;
      ed = '0;
      for (int i = 0; i < NL; i++)
        if (hit >= 0 && m_en[i]) ed[i*DW +: DW] = m_pay[hit];
      if (hit == 0) chk(link_valid == ev, "R4 first strobe", 64'(link_valid), 64'(ev));
      else chk(link_valid == ev, "R5 strobe timing", 64'(link_valid), 64'(ev));
      chk(link_data == ed, "R6 lane data", link_data, ed);
      if (mode == 2 && c == a + 3) chk(wr_reject == 1'b1, "R9 reject flag", 64'(wr_reject), 64'd1);
      if (mode == 2 && c == a + 4) chk(wr_reject == 1'b0, "R9 reject one cycle", 64'(wr_reject), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && link_valid == 0 && link_data == 0 && overrun_cnt == 0 && wr_reject == 0,
        "R1 in reset", {busy, link_valid, overrun_cnt, wr_reject}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && link_valid == 0 && link_data == 0 && overrun_cnt == 0 && wr_reject == 0,
        "R1 after reset", {busy, link_valid, overrun_cnt, wr_reject}, 64'd0);

    // increasing delays, host start then user-bit start
    for (int k = 0; k < DP; k++) load(k, k, 16'hA000 + 16'(k * 16'h0111));
    set_cfg(8, 4'b1011, 2, 1'b1);
    play(1'b0, 0);
    play(1'b1, 0);

    // all-zero delays: back-to-back ticks
    for (int k = 0; k < 5; k++) load(k, 0, 16'h5A00 + 16'(k));
    set_cfg(5, 4'b0110, 1, 1'b1);
    play(1'b0, 0);

    // maximum delay
    load(0, 15, 16'h1234); load(1, 15, 16'h4321); load(2, 3, 16'hBEEF);
    set_cfg(3, 4'b1111, 0, 1'b0);
    play(1'b0, 0);

    // R6 sweep over all link masks
    for (int m = 0; m < 16; m++) begin
      load(0, 0, 16'hC000 | 16'(m * 16'h0421));
      set_cfg(1, 4'(m), 3, 1'b0);
      play(1'b0, 0);
    end

    // R2 zero length ignores starts
    set_cfg(0, 4'b1111, 2, 1'b1);
    @(negedge clk); host_start = 1'b1;
    probe_idle("R2 zero length host", 6);
    while (cyc % TP != 0) @(negedge clk);
    user_bits = 4'b0100;
    probe_idle("R2 zero length ubit", 6);

    // R3 negative starts
    load(0, 1, 16'h7777); load(1, 0, 16'h8888);
    set_cfg(2, 4'b0101, 2, 1'b0);
    @(negedge clk); while (cyc % TP != 0) @(negedge clk);
    user_bits = 4'b0100;
    probe_idle("R3 hw disabled", 6);
    set_cfg(2, 4'b0101, 2, 1'b1);
    @(negedge clk); while (cyc % TP != 1) @(negedge clk);
    user_bits = 4'b0100;
    probe_idle("R3 off-tick", 6);
    @(negedge clk); while (cyc % TP != 0) @(negedge clk);
    user_bits = 4'b1011;
    probe_idle("R3 other bits", 6);
    play(1'b1, 0);
    chk(overrun_cnt == 0, "R8 no overrun when idle", 64'(overrun_cnt), 64'd0);

    // R8 overrun counting and saturation
    load(0, 10, 16'h0F0F); load(1, 10, 16'hF0F0);
    set_cfg(2, 4'b1001, 2, 1'b1);
    for (int r = 0; r < 3; r++) begin
      play(1'b0, 1);
      chk(overrun_cnt == 3'(ov_exp), "R8 overrun count", 64'(overrun_cnt), 64'(ov_exp));
    end

    // R9 writes during playback are dropped; replay shows old contents
    play(1'b0, 2);
    play(1'b0, 0);

    // R10 length clamp
    for (int k = 0; k < DP; k++) load(k, 1, 16'h3300 + 16'(k));
    set_cfg(15, 4'b1110, 0, 1'b0);
    play(1'b0, 0);
    chk(busy == 1'b0, "R10 stopped after DEPTH entries", 64'(busy), 64'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule